// File: doc/BRIEF.md
# Two-Wire Dimming Level Slave

This block is a byte-register slave on a two-wire SMBus-style bus. It holds one 8-bit brightness register that drives a dimming converter and three spare logic pins. A host reaches it with a Write Byte transaction to change the register, and with a Read Byte transaction to fetch the register back.

Both bus lines are sampled with the system clock and pass through a synchronizer and a glitch filter before any decoding. The block finds start and stop conditions from the filtered lines. It matches the slave address and a fixed index value, acknowledges valid bytes and shifts read data out. Data is driven only through an open-drain enable: the line is pulled low or released, and is never driven high.

The upper five register bits are inverted before they reach the converter. A larger register value therefore gives a lower analog level. The lower three bits go straight to the logic pins.

Top module: `dimsmb_top`

## Requirements
- R1: The slave answers only address byte 0x58 (7-bit address 0x2C with R/W=0) and 0x59 (R/W=1). Any other address byte is not acknowledged and the register is left unchanged.
- R2: Start, 0x58, index 0xAA, data byte, stop: each of the three bytes is acknowledged and the register takes the data byte.
- R3: Start, 0x58, index 0x00, repeated start, 0x59: both address bytes and the index are acknowledged. The slave then drives the register value MSB first. Address 0x59 is not acknowledged unless index 0x00 was acknowledged earlier in the same transaction.
- R4: In the index position, any value other than 0xAA or 0x00 is not acknowledged, and the register keeps its value.
- R5: After reset the register is 0x00, so `dac_code` is 31 and `gpo` is 0.
- R6: `dac_code` equals 31 minus register bits [7:3]. A register value of 0xF8 gives 0 and a value of 0x07 gives 31.
- R7: `gpo[2:0]` equals register bits [2:0], bit for bit, and these bits have no effect on `dac_code`.
- R8: `sda_oe` is set to 1 (pull low) only while SCL is low. A released line is always `sda_oe`=0.
- R9: A stop that arrives in the middle of a data byte ends the transaction, and the register is not updated.
- R10: An SCL pulse shorter than the filter length (default 3 clocks) is ignored and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| dac_code | output | 5 | Code for the dimming converter (31 minus level field) |
| gpo | output | 3 | Logic pins taken from register bits [2:0] |

## Verification
The assertions assume the master changes SDA only while SCL is low, except when it signals a start or a stop. They also assume every SCL phase lasts well beyond the filter delay plus the synchronizer, so the filtered lines follow the pins in order. The stimulus holds every SCL phase for 20 clocks and waits 4 clocks after each SCL fall before it moves SDA. The one exception is a single-clock SCL spike, injected on purpose to exercise the filter.

// File: rtl/dimsmb_pkg.sv
package dimsmb_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned LVL_W   = 5;
    localparam int unsigned AUX_W   = BYTE_W - LVL_W;
    localparam int unsigned BITCNT_W = $clog2(BYTE_W + 1);

    localparam logic [6:0]        DEV_ADDR  = 7'h2C;
    localparam logic [BYTE_W-1:0] IDX_WRITE = 8'hAA;
    localparam logic [BYTE_W-1:0] IDX_READ  = 8'h00;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic [AUX_W-1:0] aux;
    } bright_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_INDEX,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_IGNORE
    } slv_state_e;

    function automatic logic [LVL_W-1:0] level_to_code(input logic [LVL_W-1:0] lvl);
        return {LVL_W{1'b1}} - lvl;
    endfunction

endpackage

// File: rtl/dimsmb_glitch_filter.sv
module dimsmb_glitch_filter #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            run_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == line_o) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                line_o <= sync_q[1];
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R10: the filtered line only moves toward the synchronized value
    a_r10_follow_sync: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_o) |-> (line_o == $past(sync_q[1])));

endmodule

// File: rtl/dimsmb_bus_events.sv
module dimsmb_bus_events (
    input  logic clk,
    input  logic rst,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        start_ev = scl_f & scl_q & sda_q & ~sda_f;
        stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
        scl_rise = scl_f & ~scl_q;
        scl_fall = ~scl_f & scl_q;
    end

endmodule

// File: rtl/dimsmb_slave_fsm.sv
module dimsmb_slave_fsm
    import dimsmb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    input  logic    start_ev,
    input  logic    stop_ev,
    input  logic    scl_rise,
    input  logic    scl_fall,
    output logic    sda_oe,
    output bright_t bright
);
    slv_state_e            state, nxt_q, nxt_c;
    logic [BITCNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]     sh, tx;
    logic                  commit_q, commit_c, rd_armed, arm_c, ack_c;

    always_comb begin
        ack_c    = 1'b0;
        nxt_c    = ST_IGNORE;
        commit_c = 1'b0;
        arm_c    = 1'b0;
        unique case (state)
            ST_ADDR: begin
                if (sh[7:1] == DEV_ADDR) begin
                    if (!sh[0]) begin
                        ack_c = 1'b1;
                        nxt_c = ST_INDEX;
                    end else if (rd_armed) begin
                        ack_c = 1'b1;
                        nxt_c = ST_TX;
                    end
                end
            end
            ST_INDEX: begin
                if (sh == IDX_WRITE) begin
                    ack_c = 1'b1;
                    nxt_c = ST_WDATA;
                end else if (sh == IDX_READ) begin
                    ack_c = 1'b1;
                    arm_c = 1'b1;
                end
            end
            ST_WDATA: begin
                ack_c    = 1'b1;
                commit_c = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            nxt_q    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            tx       <= '0;
            sda_oe   <= 1'b0;
            commit_q <= 1'b0;
            rd_armed <= 1'b0;
            bright   <= '0;
        end else if (stop_ev) begin
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
            rd_armed <= 1'b0;
            commit_q <= 1'b0;
            cnt      <= '0;
        end else if (start_ev) begin
            state    <= ST_ADDR;
            sda_oe   <= 1'b0;
            commit_q <= 1'b0;
            cnt      <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_INDEX, ST_WDATA: begin
                    if (scl_rise && cnt < BITCNT_W'(BYTE_W)) begin
                        sh  <= {sh[BYTE_W-2:0], sda_f};
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall && cnt == BITCNT_W'(BYTE_W)) begin
                        if (ack_c) begin
                            sda_oe   <= 1'b1;
                            state    <= ST_ACK;
                            nxt_q    <= nxt_c;
                            commit_q <= commit_c;
                            rd_armed <= rd_armed | arm_c;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt      <= '0;
                        state    <= nxt_q;
                        commit_q <= 1'b0;
                        if (commit_q) bright <= bright_t'(sh);
                        if (nxt_q == ST_TX) begin
                            tx     <= BYTE_W'(bright);
                            sda_oe <= ~bright[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt == BITCNT_W'(BYTE_W - 1)) begin
                            sda_oe <= 1'b0;
                            state  <= ST_IGNORE;
                        end else begin
                            sda_oe <= ~tx[BYTE_W-2];
                            tx     <= {tx[BYTE_W-2:0], 1'b0};
                            cnt    <= cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R8: the pull-down turns on only after SCL has been seen low
    a_r8_pull_on_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_f));

    // R2 / R9: register moves only at the end of an acknowledged data byte
    a_r9_commit_point: assert property (@(posedge clk) disable iff (rst)
        !$stable(bright) |-> ($past(state) == ST_ACK && $past(scl_fall) && $past(commit_q)));

    // R10: never more than one byte of bits is collected
    a_r10_bit_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= BITCNT_W'(BYTE_W));

    // R1 / R3: acknowledging a read address requires an armed read
    a_r3_read_armed: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK && nxt_q == ST_TX) |-> rd_armed);

endmodule

// File: rtl/dimsmb_top.sv
module dimsmb_top
    import dimsmb_pkg::*;
#(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [LVL_W-1:0] dac_code,
    output logic [AUX_W-1:0] gpo
);
    localparam int unsigned NLINES = 2;

    logic [NLINES-1:0] raw, filt;
    logic              start_ev, stop_ev, scl_rise, scl_fall;
    bright_t           bright;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        dimsmb_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw[g]),
            .line_o (filt[g])
        );
    end

    dimsmb_bus_events u_events (
        .clk      (clk),
        .rst      (rst),
        .scl_f    (filt[0]),
        .sda_f    (filt[1]),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    dimsmb_slave_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .scl_f    (filt[0]),
        .sda_f    (filt[1]),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_oe   (sda_oe),
        .bright   (bright)
    );

    assign dac_code = level_to_code(bright.level);
    assign gpo      = bright.aux;

    // R8: no pull-down while the bus is idle after a stop
    a_r8_idle_released: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_oe);

endmodule

// File: tb/dimsmb_top_bench.sv
module dimsmb_top_bench;

    localparam int HALF = 20;
    localparam int NVEC = 8;
    localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'hF8, 8'hFF, 8'h07,
                                          8'h5A, 8'hA5, 8'h80, 8'h0B};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [4:0] dac_code;
    logic [2:0] gpo;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    int r8_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    dimsmb_top u_dimsmb_top (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .dac_code (dac_code),
        .gpo      (gpo)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R8 monitor: pull-down may only begin while the raw clock line is low
    logic oe_d = 1'b0;
    always @(negedge clk) begin
        if (!rst && sda_oe && !oe_d && scl_m) r8_bad++;
        oe_d <= sda_oe;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wclk(HALF);
        sda_m = 1'b0; wclk(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_rstart();
        wclk(4); sda_m = 1'b1; wclk(HALF);
        scl_m = 1'b1; wclk(HALF);
        sda_m = 1'b0; wclk(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wclk(4); sda_m = 1'b0; wclk(HALF);
        scl_m = 1'b1; wclk(HALF);
        sda_m = 1'b1; wclk(HALF);
    endtask

    task automatic put_bit(input logic b);
        wclk(4); sda_m = b; wclk(HALF);
        scl_m = 1'b1; wclk(HALF);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit spike, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            wclk(4); sda_m = b[i]; wclk(4);
            if (spike && i == 3) begin
                scl_m = 1'b1; wclk(1); scl_m = 1'b0;
            end
            wclk(HALF - 4);
            scl_m = 1'b1; wclk(HALF);
            scl_m = 1'b0;
        end
        wclk(4); sda_m = 1'b1; wclk(HALF);
        scl_m = 1'b1; wclk(HALF / 2);
        acked = ~sda_line;
        wclk(HALF / 2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(4 + HALF);
            scl_m = 1'b1; wclk(HALF / 2);
            b[i] = sda_line;
            wclk(HALF / 2);
            scl_m = 1'b0;
        end
        put_bit(1'b1);
    endtask

    task automatic do_write(input logic [7:0] idx, input logic [7:0] d, input bit spike,
                            output bit a0, output bit a1, output bit a2);
        bus_start();
        send_byte(8'h58, 1'b0, a0);
        send_byte(idx, 1'b0, a1);
        send_byte(d, spike, a2);
        bus_stop();
    endtask

    task automatic do_read(output logic [7:0] d, output bit a0, output bit a1, output bit a2);
        bus_start();
        send_byte(8'h58, 1'b0, a0);
        send_byte(8'h00, 1'b0, a1);
        bus_rstart();
        send_byte(8'h59, 1'b0, a2);
        recv_byte(d);
        bus_stop();
    endtask

    initial begin
        bit a0, a1, a2;
        logic [7:0] rd;

        wclk(5); rst = 1'b0; wclk(5);
        // R5 reset state
        chk("R5 dac after reset", dac_code, 31);
        chk("R5 gpo after reset", gpo, 0);
        chk("R8 idle released", sda_oe, 0);

        // R2 R3 R6 R7 table walk
        for (int v = 0; v < NVEC; v++) begin
            do_write(8'hAA, VEC[v], 1'b0, a0, a1, a2);
            chk("R2 write acks", {a0, a1, a2}, 3'b111);
            chk("R6 dac code", dac_code, 31 - (VEC[v] >> 3));
            chk("R7 gpo bits", gpo, VEC[v] & 8'h07);
            do_read(rd, a0, a1, a2);
            chk("R3 read acks", {a0, a1, a2}, 3'b111);
            chk("R3 readback", rd, VEC[v]);
        end

        // R1 wrong address
        do_write(8'hAA, 8'h00, 1'b0, a0, a1, a2);
        bus_start(); send_byte(8'h5A, 1'b0, a0); send_byte(8'hAA, 1'b0, a1);
        send_byte(8'hF8, 1'b0, a2); bus_stop();
        chk("R1 foreign address nack", a0, 0);
        chk("R1 register kept", dac_code, 31);

        // R4 bad index
        do_write(8'h55, 8'hF8, 1'b0, a0, a1, a2);
        chk("R4 index nack", {a0, a1}, 2'b10);
        chk("R4 register kept", dac_code, 31);

        // R3 read address without armed index
        bus_start(); send_byte(8'h59, 1'b0, a0); bus_stop();
        chk("R3 unarmed read nack", a0, 0);

        // R9 stop mid data byte
        do_write(8'hAA, 8'h33, 1'b0, a0, a1, a2);
        bus_start(); send_byte(8'h58, 1'b0, a0); send_byte(8'hAA, 1'b0, a1);
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        chk("R9 abort dac kept", dac_code, 31 - (8'h33 >> 3));
        chk("R9 abort gpo kept", gpo, 3);

        // R10 short SCL spike ignored
        do_write(8'hAA, 8'hC6, 1'b1, a0, a1, a2);
        chk("R10 spike acks", {a0, a1, a2}, 3'b111);
        chk("R10 spike dac", dac_code, 31 - (8'hC6 >> 3));
        chk("R10 spike gpo", gpo, 6);

        // R5 reset during operation
        wclk(3); rst = 1'b1; wclk(3); rst = 1'b0; wclk(3);
        chk("R5 dac after second reset", dac_code, 31);
        chk("R5 gpo after second reset", gpo, 0);

        chk("R8 pull-down only while SCL low", r8_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule